// File: doc/BRIEF.md
# Match-Controlled Multi-Channel PWM Timer

This block is a pulse-width timer built around one up-counter. A prescaler divides the clock: each time the prescaler reaches its programmed limit it wraps and lets the main counter advance by one. Seven compare values are checked against the counter on every advance. For each compare value, three action bits choose what a match does. It can latch an interrupt flag, send the counter back to zero, or freeze the counter and drop its run bit.

Six outputs are derived from the match events. Channel 1 and any channel left in single-edge mode rise when compare 0 matches, which is the period end, and fall on their own compare. Channels 2 to 6 can each be switched to double-edge mode. In that mode the channel rises on the compare of the channel below it and falls on its own compare. Each output is gated by its own enable bit. Software reaches every setting through a simple word-wide write port with a combinational read.

Top module: `pwm_match_timer`

## Requirements
- R1: While running and not held, the prescale count steps 0,1,..,limit and then returns to 0. The main count advances by one on each of those wraps, so after j clocks from start the count equals floor(j/(limit+1)).
- R2: Control register (address 0) bit 0 is run and bit 1 is hold. With run at 0, both counts keep their value. With hold at 1, both counts are forced to 0 and all channel states are cleared.
- R3: A match on compare k happens when the prescaler wraps while the count equals compare k (address 8+k). If the reset action is set, the count goes to 0 on that clock edge instead of advancing.
- R4: If the stop action is set on a match, the count keeps the matched value and the prescale count stays 0. Run bit 0 of the control register reads 0 from then on.
- R5: Action register (address 4) holds 3 bits per compare k: bit 3k is interrupt, 3k+1 is reset and 3k+2 is stop. With the interrupt bit set, a match sets flag k in address 6. Writing 1 to a flag bit clears it. The irq output is the OR of all flags, and a match whose interrupt bit is 0 sets no flag.
- R6: In single-edge mode, channel n goes high on a compare-0 match and low on a compare-n match. When both occur together, low wins.
- R7: Channel configuration (address 5) bits 2..6 select double-edge mode (1) for channels 2..6. A double-edge channel n goes high on a compare n-1 match and low on a compare n match. Channel 1 is always single-edge.
- R8: Address 5 bits 9..14 enable outputs 1..6. Output n (pwm_out bit n-1) drives its state only while its enable is 1 and is 0 otherwise.
- R9: After reset every register, flag, output and irq reads 0. Bits 0, 1, 7, 8 and 15 of address 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pwm_out | output | NUM_CH (6) | Gated channel outputs, bit n-1 is channel n |
| irq | output | 1 | OR of all pending match flags |

## Verification
The bench builds the block with an 8-bit counter and an 8-bit prescaler and keeps six channels. This keeps periods short enough to sweep every counter value over three full periods, for prescale limits 0, 1 and 2. Two compare sets are used. The first puts channels at compare values below, equal to and above the period, so both ends of single-edge duty are covered. The second mixes double-edge and single-edge channels. The stop, interrupt-flag and freeze paths are then each exercised from a fresh start, with a small enough period that the matched value is reached within a few dozen clocks.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;

    // register word addresses; compare k lives at MVAL_BASE + k
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRESC = 4'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd2;
    localparam logic [ADDR_W-1:0] A_PCNT  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MACT  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CCFG  = 4'd5;
    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd6;

    typedef struct packed {
        logic hold;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic stop;
        logic clr;
        logic irq;
    } mact_t;

    // pick the three action bits for compare k out of a register word
    function automatic mact_t mact_of(input logic [REG_W-1:0] word, input int k);
        mact_t a;
        a.irq  = word[3*k];
        a.clr  = word[3*k+1];
        a.stop = word[3*k+2];
        return a;
    endfunction

    // is this address the compare slot for index k
    function automatic logic is_mval(input logic [ADDR_W-1:0] a, input int k);
        return a[ADDR_W-1] && (int'(a[ADDR_W-2:0]) == k);
    endfunction

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  logic [PRE_W-1:0] limit,
    output logic [PRE_W-1:0] pcnt,
    output logic             tick
);

    assign tick = run && !hold && (pcnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pcnt == '0));

    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !hold) |=> $stable(pcnt));

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             tick,
    input  logic             any_clr,
    input  logic             any_stop,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            count <= '0;
        end else if (tick) begin
            if (any_clr) begin
                count <= '0;
            end else if (!any_stop) begin
                count <= count + 1'b1;
            end
        end
    end

    assert_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !any_clr && !any_stop) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_hold_zero_R2: assert property (@(posedge clk) disable iff (rst)
        hold |=> (count == '0));

    assert_no_tick_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hold) |=> $stable(count));

    assert_match_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && any_clr) |=> (count == '0));

    assert_stop_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && any_stop && !any_clr) |=> $stable(count));

endmodule

// File: rtl/pwmt_match.sv
module pwmt_match
    import pwmt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 7
) (
    input  logic                                tick,
    input  logic [CNT_W-1:0]                    count,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0]     mval,
    input  mact_t [NUM_MATCH-1:0]               mact,
    output logic [NUM_MATCH-1:0]                evt,
    output logic [NUM_MATCH-1:0]                irq_hit,
    output logic                                any_clr,
    output logic                                any_stop
);

    logic [NUM_MATCH-1:0] clr_hit;
    logic [NUM_MATCH-1:0] stop_hit;

    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
        assign evt[k]      = tick && (count == mval[k]);
        assign irq_hit[k]  = evt[k] && mact[k].irq;
        assign clr_hit[k]  = evt[k] && mact[k].clr;
        assign stop_hit[k] = evt[k] && mact[k].stop;
    end

    assign any_clr  = |clr_hit;
    assign any_stop = |stop_hit;

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic dbl,
    input  logic en,
    input  logic evt_period,
    input  logic evt_prev,
    input  logic evt_own,
    output logic pin
);

    logic state;
    logic rise;

    assign rise = dbl ? evt_prev : evt_period;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            state <= 1'b0;
        end else if (evt_own) begin
            state <= 1'b0;
        end else if (rise) begin
            state <= 1'b1;
        end
    end

    assign pin = en & state;

    assert_fall_wins_R6: assert property (@(posedge clk) disable iff (rst)
        evt_own |=> !state);

    assert_rise_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (rise && !evt_own && !hold) |=> state);

endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 32,
    parameter int NUM_CH = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_we,
    input  logic [3:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic [NUM_CH-1:0]       pwm_out,
    output logic                    irq
);

    localparam int NUM_MATCH = NUM_CH + 1;
    localparam int ENA_BASE  = NUM_CH + 3;

    ctrl_t                           ctrl_q;
    logic [PRE_W-1:0]                presc_q;
    mact_t [NUM_MATCH-1:0]           mact_q;
    logic [NUM_MATCH-1:0][CNT_W-1:0] mval_q;
    logic [NUM_CH-1:1]               mode_q;
    logic [NUM_CH-1:0]               ena_q;
    logic [NUM_MATCH-1:0]            flags_q;

    logic [NUM_CH-1:0]    dbl_v;
    logic [PRE_W-1:0]     pcnt;
    logic                 tick;
    logic [CNT_W-1:0]     count;
    logic [NUM_MATCH-1:0] evt;
    logic [NUM_MATCH-1:0] irq_hit;
    logic                 any_clr;
    logic                 any_stop;
    logic [NUM_MATCH-1:0] w1c_mask;

    logic wr_ctrl, wr_presc, wr_mact, wr_ccfg, wr_flags;

    assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
    assign wr_presc = reg_we && (reg_addr == A_PRESC);
    assign wr_mact  = reg_we && (reg_addr == A_MACT);
    assign wr_ccfg  = reg_we && (reg_addr == A_CCFG);
    assign wr_flags = reg_we && (reg_addr == A_FLAGS);

    assign dbl_v    = {mode_q, 1'b0};
    assign w1c_mask = wr_flags ? reg_wdata[NUM_MATCH-1:0] : '0;

    // control: a stop match overrides a same-cycle software write
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run  <= reg_wdata[0];
                ctrl_q.hold <= reg_wdata[1];
            end
            if (any_stop) begin
                ctrl_q.run <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            mact_q  <= '0;
            mode_q  <= '0;
            ena_q   <= '0;
        end else begin
            if (wr_presc) begin
                presc_q <= reg_wdata[PRE_W-1:0];
            end
            if (wr_mact) begin
                for (int k = 0; k < NUM_MATCH; k++) begin
                    mact_q[k] <= mact_of(reg_wdata, k);
                end
            end
            if (wr_ccfg) begin
                for (int c = 1; c < NUM_CH; c++) begin
                    mode_q[c] <= reg_wdata[c+1];
                end
                for (int c = 0; c < NUM_CH; c++) begin
                    ena_q[c] <= reg_wdata[ENA_BASE+c];
                end
            end
        end
    end

    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_mval
        always_ff @(posedge clk) begin
            if (rst) begin
                mval_q[k] <= '0;
            end else if (reg_we && is_mval(reg_addr, k)) begin
                mval_q[k] <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    // flags: a new match wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~w1c_mask) | irq_hit;
        end
    end

    assign irq = |flags_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[3]) begin
            for (int k = 0; k < NUM_MATCH; k++) begin
                if (is_mval(reg_addr, k)) begin
                    reg_rdata = 32'(mval_q[k]);
                end
            end
        end else begin
            case (reg_addr)
                A_CTRL:  reg_rdata = 32'({ctrl_q.hold, ctrl_q.run});
                A_PRESC: reg_rdata = 32'(presc_q);
                A_COUNT: reg_rdata = 32'(count);
                A_PCNT:  reg_rdata = 32'(pcnt);
                A_MACT: begin
                    for (int k = 0; k < NUM_MATCH; k++) begin
                        reg_rdata[3*k +: 3] = mact_q[k];
                    end
                end
                A_CCFG: begin
                    for (int c = 1; c < NUM_CH; c++) begin
                        reg_rdata[c+1] = mode_q[c];
                    end
                    for (int c = 0; c < NUM_CH; c++) begin
                        reg_rdata[ENA_BASE+c] = ena_q[c];
                    end
                end
                A_FLAGS: reg_rdata = 32'(flags_q);
                default: reg_rdata = '0;
            endcase
        end
    end

    pwmt_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl_q.run),
        .hold  (ctrl_q.hold),
        .limit (presc_q),
        .pcnt  (pcnt),
        .tick  (tick)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .hold     (ctrl_q.hold),
        .tick     (tick),
        .any_clr  (any_clr),
        .any_stop (any_stop),
        .count    (count)
    );

    pwmt_match #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_match (
        .tick     (tick),
        .count    (count),
        .mval     (mval_q),
        .mact     (mact_q),
        .evt      (evt),
        .irq_hit  (irq_hit),
        .any_clr  (any_clr),
        .any_stop (any_stop)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwmt_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .hold       (ctrl_q.hold),
            .dbl        (dbl_v[c]),
            .en         (ena_q[c]),
            .evt_period (evt[0]),
            .evt_prev   (evt[c]),
            .evt_own    (evt[c+1]),
            .pin        (pwm_out[c])
        );
    end

    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_flag_chk
        assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
            irq_hit[k] |=> flags_q[k]);
        assert_flag_w1c_R5: assert property (@(posedge clk) disable iff (rst)
            (w1c_mask[k] && !irq_hit[k]) |=> !flags_q[k]);
    end

    assert_stop_drops_run_R4: assert property (@(posedge clk) disable iff (rst)
        any_stop |=> !ctrl_q.run);

    assert_irq_follows_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (flags_q == '0) |-> !irq);

endmodule

// File: tb/pwm_match_timer_test.sv
module pwm_match_timer_test;

    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] pwm_out;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int mr [7];
    bit dbl [7];
    bit ena [7];

    always #10 clk = ~clk;

    pwm_match_timer #(.CNT_W(8), .PRE_W(8), .NUM_CH(NCH)) uut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // call at a falling edge; returns at the falling edge after the write
    task automatic wr(input logic [3:0] a, input int d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic int ccfg_word();
        int w = 0;
        for (int n = 2; n <= 6; n++) if (dbl[n]) w |= (1 << n);
        for (int n = 1; n <= 6; n++) if (ena[n]) w |= (1 << (8 + n));
        return w;
    endfunction

    function automatic int exp_pin(input int n, input int tc, input bit wrapped);
        if (!ena[n]) return 0;
        if (dbl[n]) return int'(tc > mr[n-1] && tc <= mr[n]);
        return int'(wrapped && mr[n] != mr[0] && tc <= mr[n]);
    endfunction

    task automatic setup(input int p, input int mact);
        wr(4'd0, 2);
        wr(4'd1, p);
        for (int k = 0; k < 7; k++) wr(4'(8 + k), mr[k]);
        wr(4'd4, mact);
        wr(4'd5, ccfg_word());
        wr(4'd6, 32'h7f);
        wr(4'd0, 1);
    endtask

    task automatic sweep(input int p);
        int tcv, pcv, ticks, etc;
        bit wrapped;
        setup(p, 2);
        for (int j = 0; j < (mr[0] + 1) * (p + 1) * 3; j++) begin
            ticks   = j / (p + 1);
            etc     = ticks % (mr[0] + 1);
            wrapped = ticks > mr[0];
            rd(4'd2, tcv);
            rd(4'd3, pcv);
            chk("R1 R3 count", tcv, etc);
            chk("R1 prescale", pcv, j % (p + 1));
            for (int n = 1; n <= 6; n++) begin
                // R6 R7 R8 channel level from counter position
                chk($sformatf("R6 R7 R8 channel %0d", n), int'(pwm_out[n-1]),
                    exp_pin(n, etc, wrapped));
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int v, t0, t1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        for (int a = 0; a < 15; a++) begin
            if (a != 7) begin
                rd(4'(a), v);
                chk($sformatf("R9 reset reg %0d", a), v, 0);
            end
        end
        chk("R9 reset outputs", int'(pwm_out), 0);
        chk("R9 reset irq", int'(irq), 0);

        // R9 reserved bits, R7 channel 1 has no mode bit
        wr(4'd5, 32'hffff);
        rd(4'd5, v);
        chk("R9 R7 config readback", v, 32'h7e7c);

        // configuration A: single-edge, edges below/at/above period
        mr = '{9, 2, 4, 6, 7, 9, 12};
        dbl = '{0, 0, 0, 0, 0, 0, 0};
        ena = '{0, 1, 1, 0, 1, 1, 1};
        for (int p = 0; p < 3; p++) sweep(p);

        // R2 run cleared freezes the counts
        wr(4'd0, 0);
        rd(4'd2, t0);
        rd(4'd3, v);
        repeat (5) @(negedge clk);
        rd(4'd2, t1);
        chk("R2 frozen count", t1, t0);
        rd(4'd3, t1);
        chk("R2 frozen prescale", t1, v);

        // configuration B: double-edge mix
        mr = '{11, 1, 4, 6, 8, 3, 10};
        dbl = '{0, 0, 1, 1, 1, 0, 1};
        ena = '{0, 1, 1, 1, 1, 1, 1};
        for (int p = 0; p < 3; p++) sweep(p);

        // R2 hold forces zero and clears channels
        wr(4'd0, 3);
        repeat (3) @(negedge clk);
        rd(4'd2, v);
        chk("R2 hold count", v, 0);
        rd(4'd3, v);
        chk("R2 hold prescale", v, 0);
        chk("R2 hold channels", int'(pwm_out), 0);

        // R4 R5 stop and interrupt flags
        mr = '{200, 1, 3, 5, 4, 3, 10};
        ena = '{0, 0, 0, 0, 0, 0, 0};
        dbl = '{0, 0, 0, 0, 0, 0, 0};
        setup(1, (1 << 6) | (1 << 9) | (1 << 11));
        repeat (30) @(negedge clk);
        rd(4'd2, v);
        chk("R4 stopped count", v, 5);
        rd(4'd3, v);
        chk("R4 stopped prescale", v, 0);
        rd(4'd0, v);
        chk("R4 run bit cleared", v, 0);
        rd(4'd6, v);
        chk("R5 flags after matches", v, 32'h0c);
        chk("R5 irq raised", int'(irq), 1);
        chk("R8 disabled outputs", int'(pwm_out), 0);
        wr(4'd6, 32'h08);
        rd(4'd6, v);
        chk("R5 one flag cleared", v, 32'h04);
        chk("R5 irq still raised", int'(irq), 1);
        wr(4'd6, 32'h04);
        rd(4'd6, v);
        chk("R5 all flags cleared", v, 0);
        chk("R5 irq dropped", int'(irq), 0);
        repeat (4) @(negedge clk);
        rd(4'd2, v);
        chk("R4 count stays stopped", v, 5);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule